// File: doc/BRIEF.md
# Four-to-Two Receive Lane Merge Stage

This stage sits after four per-lane receive FIFOs. Each FIFO holds 66-bit blocks of one virtual lane. The stage narrows the four lanes to a datapath two words wide. It reads the even-numbered lane pair (lanes 0 and 2) on one cycle and the odd-numbered pair (lanes 1 and 3) on the next. Each FIFO is therefore read on only every other cycle. At 312.5 MHz the two output slots still carry about 41.25 Gb/s of raw 66-bit blocks.

Each output slot is shared by two virtual lanes in time order. Slot 0 alternates lane 0 and lane 1. Slot 1 alternates lane 2 and lane 3. Every output word carries a valid flag and a 2-bit lane tag. The output is registered, so a word appears one cycle after the cycle in which its FIFO was read.

The input side of each lane follows valid/ready rules. `lane_valid` means the FIFO is not empty. `lane_rd` is the ready from the stage. A block leaves the FIFO only in a cycle where both are high. The output side has no back-pressure: the consumer must take every word while `out_valid` is high.

Top module: `lane_merge4to2`

## Requirements
- R1: While `rst` is high, `lane_rd` is 0000. On the clock edge where `rst` is sampled high, `out_valid`, `out_lane` and `out_data` are all cleared to zero.
- R2: In the first enabled cycle after reset, the even pair is read: `lane_rd` = 4'b0101.
- R3: While `en` is high, `lane_rd` alternates between 4'b0101 (lanes 0 and 2) and 4'b1010 (lanes 1 and 3) on every cycle. No cycle reads a lane of each parity.
- R4: While `en` is low, `lane_rd` is 0000 and the phase does not advance. The first enabled cycle after a pause reads the pair opposite to the last pair read. `out_valid` is 00 on the cycle after an idle cycle, and tags and data hold their values.
- R5: Slot 0 (`out_data[65:0]`, `out_lane[1:0]`) carries lane 0 after an even read and lane 1 after an odd read. Slot 1 (`out_data[131:66]`, `out_lane[3:2]`) carries lane 2 after an even read and lane 3 after an odd read. Each tag holds the lane number in binary.
- R6: A block accepted on a clock edge (`lane_rd` and `lane_valid` both high) appears on its slot with `out_valid` high right after that same edge, which is one cycle of latency.
- R7: If the lane being read reports empty, that slot's `out_valid` is low on the next cycle. Its tag still names the lane that was read, and its `out_data` keeps the last accepted block. The other slot is not affected.
- R8: A lane whose FIFO is non-empty is not consumed in a cycle where its `lane_rd` is low. Only the scheduled pair is offered ready, whatever the `lane_valid` pattern is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Stage enable; phase advances only while high |
| lane_valid | input | 4 | Per-lane FIFO non-empty flag |
| lane_data | input | 264 | Four 66-bit lane blocks, lane n at bits [66n+65:66n] |
| lane_rd | output | 4 | Per-lane FIFO read enable (ready) |
| out_valid | output | 2 | Per-slot word valid |
| out_lane | output | 4 | Per-slot 2-bit source lane tag, slot n at bits [2n+1:2n] |
| out_data | output | 132 | Two 66-bit output words, slot n at bits [66n+65:66n] |

## Verification
Two things can happen in the same cycle. One slot can receive an empty-lane read while the other slot delivers a valid word. The phase toggle can also meet a drop of `en`. The directed scenarios apply lane-valid patterns that make the two slots differ on both parities. They also insert one-cycle and two-cycle enable gaps in the middle of a stream. Each cycle is judged against a bench model of the phase. The model checks the read-enable pattern before the edge, then the valid bit, tag and held data of both slots after it. The pause cases show that the phase resumes correctly and that the slot which was not read keeps its contents.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } lm_phase_e;

  function automatic int lane_for_slot(input int slot, input lm_phase_e ph);
    return 2 * slot + ((ph == PH_ODD) ? 1 : 0);
  endfunction

endpackage

// File: rtl/lm_phase.sv
module lm_phase
  import lm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  output lm_phase_e phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_EVEN;
    end else if (en) begin
      phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
  end

endmodule

// File: rtl/lm_read_ctrl.sv
module lm_read_ctrl
  import lm_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 rst,
  input  logic                 en,
  input  lm_phase_e            phase,
  output logic [NUM_LANES-1:0] lane_rd
);

  logic active;
  assign active = en && !rst;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam lm_phase_e LANE_PH = ((l % 2) == 1) ? PH_ODD : PH_EVEN;
    assign lane_rd[l] = active && (phase == LANE_PH);
  end

endmodule

// File: rtl/lm_slot.sv
module lm_slot
  import lm_pkg::*;
#(
  parameter int LANE_W = 66,
  parameter int TAG_W  = 2,
  parameter int SLOT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  lm_phase_e         phase,
  input  logic              even_vld,
  input  logic [LANE_W-1:0] even_data,
  input  logic              odd_vld,
  input  logic [LANE_W-1:0] odd_data,
  output logic              slot_vld,
  output logic [TAG_W-1:0]  slot_tag,
  output logic [LANE_W-1:0] slot_data
);

  localparam logic [TAG_W-1:0] EVEN_TAG = TAG_W'(lane_for_slot(SLOT, PH_EVEN));
  localparam logic [TAG_W-1:0] ODD_TAG  = TAG_W'(lane_for_slot(SLOT, PH_ODD));

  logic              sel_vld;
  logic [LANE_W-1:0] sel_data;
  logic [TAG_W-1:0]  sel_tag;

  always_comb begin
    if (phase == PH_ODD) begin
      sel_vld  = odd_vld;
      sel_data = odd_data;
      sel_tag  = ODD_TAG;
    end else begin
      sel_vld  = even_vld;
      sel_data = even_data;
      sel_tag  = EVEN_TAG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld  <= 1'b0;
      slot_tag  <= '0;
      slot_data <= '0;
    end else if (en) begin
      slot_vld <= sel_vld;
      slot_tag <= sel_tag;
      if (sel_vld) begin
        slot_data <= sel_data;
      end
    end else begin
      slot_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/lane_merge4to2.sv
module lane_merge4to2
  import lm_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 66
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic [NUM_LANES-1:0]              lane_valid,
  input  logic [NUM_LANES*LANE_W-1:0]       lane_data,
  output logic [NUM_LANES-1:0]              lane_rd,
  output logic [NUM_LANES/2-1:0]            out_valid,
  output logic [NUM_LANES/2*$clog2(NUM_LANES)-1:0] out_lane,
  output logic [NUM_LANES/2*LANE_W-1:0]     out_data
);

  localparam int NUM_SLOTS = NUM_LANES / 2;
  localparam int TAG_W     = $clog2(NUM_LANES);

  lm_phase_e phase;

  lm_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .phase (phase)
  );

  lm_read_ctrl #(
    .NUM_LANES (NUM_LANES)
  ) u_rdctl (
    .rst     (rst),
    .en      (en),
    .phase   (phase),
    .lane_rd (lane_rd)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int LE = 2 * s;
    localparam int LO = 2 * s + 1;
    lm_slot #(
      .LANE_W (LANE_W),
      .TAG_W  (TAG_W),
      .SLOT   (s)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .phase     (phase),
      .even_vld  (lane_valid[LE]),
      .even_data (lane_data[LE*LANE_W +: LANE_W]),
      .odd_vld   (lane_valid[LO]),
      .odd_data  (lane_data[LO*LANE_W +: LANE_W]),
      .slot_vld  (out_valid[s]),
      .slot_tag  (out_lane[s*TAG_W +: TAG_W]),
      .slot_data (out_data[s*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/lane_merge4to2_chk.sv
module lane_merge4to2_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 66
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              en,
  input logic [NUM_LANES-1:0]              lane_valid,
  input logic [NUM_LANES*LANE_W-1:0]       lane_data,
  input logic [NUM_LANES-1:0]              lane_rd,
  input logic [NUM_LANES/2-1:0]            out_valid,
  input logic [NUM_LANES/2*$clog2(NUM_LANES)-1:0] out_lane,
  input logic [NUM_LANES/2*LANE_W-1:0]     out_data
);

  localparam int NUM_SLOTS = NUM_LANES / 2;
  localparam int TAG_W     = $clog2(NUM_LANES);
  localparam logic [NUM_LANES-1:0] EVEN_MASK = {NUM_SLOTS{2'b01}};
  localparam logic [NUM_LANES-1:0] ODD_MASK  = {NUM_SLOTS{2'b10}};

  assert_no_read_in_reset_R1: assert property (@(posedge clk)
    rst |-> (lane_rd == '0));

  assert_outputs_cleared_R1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && out_lane == '0 && out_data == '0));

  assert_pair_split_R3: assert property (@(posedge clk) disable iff (rst)
    !(((lane_rd & EVEN_MASK) != '0) && ((lane_rd & ODD_MASK) != '0)));

  assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst)) |-> (lane_rd != '0 && lane_rd != $past(lane_rd)));

  assert_idle_no_valid_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_valid == '0));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam int S = l / 2;
    assert_take_word_R6: assert property (@(posedge clk) disable iff (rst)
      (lane_rd[l] && lane_valid[l]) |=>
        (out_valid[S] && out_lane[S*TAG_W +: TAG_W] == TAG_W'(l)
         && out_data[S*LANE_W +: LANE_W] == $past(lane_data[l*LANE_W +: LANE_W])));

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (lane_rd[l] && !lane_valid[l]) |=>
        (!out_valid[S] && out_lane[S*TAG_W +: TAG_W] == TAG_W'(l)
         && $stable(out_data[S*LANE_W +: LANE_W])));
  end

endmodule

bind lane_merge4to2 lane_merge4to2_chk #(
  .NUM_LANES (NUM_LANES),
  .LANE_W    (LANE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .lane_valid (lane_valid),
  .lane_data  (lane_data),
  .lane_rd    (lane_rd),
  .out_valid  (out_valid),
  .out_lane   (out_lane),
  .out_data   (out_data)
);

// File: tb/lane_merge4to2_test.sv
module lane_merge4to2_test;

  localparam int CLK_P = 10;
  localparam int NL    = 4;
  localparam int W     = 66;
  localparam int NS    = 2;
  localparam int TW    = 2;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic [NL-1:0]     lane_valid = '0;
  logic [NL*W-1:0]   lane_data = '0;
  logic [NL-1:0]     lane_rd;
  logic [NS-1:0]     out_valid;
  logic [NS*TW-1:0]  out_lane;
  logic [NS*W-1:0]   out_data;

  lane_merge4to2 uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .lane_valid (lane_valid),
    .lane_data  (lane_data),
    .lane_rd    (lane_rd),
    .out_valid  (out_valid),
    .out_lane   (out_lane),
    .out_data   (out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit armed  = 1'b0;
  int seq    = 0;

  logic          m_ph = 1'b0;
  logic [NS-1:0] m_vld = '0;
  logic [TW-1:0] m_tag [NS];
  logic [W-1:0]  m_dat [NS];

  function automatic logic [W-1:0] pat(int l, int s);
    return {2'(l), 32'(s * 7 + 1), 32'(s) ^ (32'(l) << 28) ^ 32'h5A5A0F0F};
  endfunction

  task automatic chk(bit ok, string req, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic step(logic r, logic e, logic [NL-1:0] iv, string req);
    logic [NL-1:0] exp_rd;
    @(negedge clk);
    if (armed) begin
      for (int s = 0; s < NS; s++) begin
        chk(out_valid[s] == m_vld[s] && out_lane[s*TW +: TW] == m_tag[s]
            && out_data[s*W +: W] == m_dat[s], req,
            $sformatf("slot%0d v=%0b t=%0d d=%h", s, out_valid[s],
                      out_lane[s*TW +: TW], out_data[s*W +: W]),
            $sformatf("slot%0d v=%0b t=%0d d=%h", s, m_vld[s], m_tag[s], m_dat[s]));
      end
    end
    rst = r;
    en = e;
    lane_valid = iv;
    seq++;
    for (int l = 0; l < NL; l++) lane_data[l*W +: W] = pat(l, seq);
    #1;
    exp_rd = (r || !e) ? 4'b0000 : (m_ph ? 4'b1010 : 4'b0101);
    chk(lane_rd == exp_rd, req, $sformatf("rd=%b", lane_rd), $sformatf("rd=%b", exp_rd));
    if (r) begin
      m_ph = 1'b0;
      m_vld = '0;
      for (int s = 0; s < NS; s++) begin
        m_tag[s] = '0;
        m_dat[s] = '0;
      end
      armed = 1'b1;
    end else if (e) begin
      for (int s = 0; s < NS; s++) begin
        int l;
        l = 2 * s + (m_ph ? 1 : 0);
        m_vld[s] = iv[l];
        m_tag[s] = TW'(l);
        if (iv[l]) m_dat[s] = pat(l, seq);
      end
      m_ph = ~m_ph;
    end else begin
      m_vld = '0;
    end
  endtask

  task automatic t_reset();
    step(1'b1, 1'b0, 4'b1111, "R1");
    step(1'b1, 1'b0, 4'b1111, "R1");
    step(1'b1, 1'b1, 4'b1111, "R1");
  endtask

  task automatic t_stream();
    step(1'b0, 1'b1, 4'b1111, "R2");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 4'b1111, "R3 R5 R6");
  endtask

  task automatic t_empty_mix();
    step(1'b0, 1'b1, 4'b0110, "R7");
    step(1'b0, 1'b1, 4'b1001, "R7");
    step(1'b0, 1'b1, 4'b0011, "R7");
    step(1'b0, 1'b1, 4'b1100, "R7");
    step(1'b0, 1'b1, 4'b0000, "R7");
    step(1'b0, 1'b1, 4'b0000, "R7");
    step(1'b0, 1'b1, 4'b1111, "R7");
  endtask

  task automatic t_pause();
    step(1'b0, 1'b1, 4'b1111, "R4");
    step(1'b0, 1'b0, 4'b1111, "R4");
    step(1'b0, 1'b1, 4'b1111, "R4");
    step(1'b0, 1'b1, 4'b1111, "R4");
    step(1'b0, 1'b0, 4'b1111, "R4");
    step(1'b0, 1'b0, 4'b0101, "R4");
    step(1'b0, 1'b1, 4'b1010, "R4");
    step(1'b0, 1'b1, 4'b1111, "R4");
  endtask

  task automatic t_offered_not_taken();
    step(1'b0, 1'b1, 4'b1010, "R8");
    step(1'b0, 1'b1, 4'b0101, "R8");
    step(1'b0, 1'b1, 4'b1111, "R8");
  endtask

  task automatic t_reset_mid();
    step(1'b0, 1'b1, 4'b1111, "R1");
    step(1'b1, 1'b1, 4'b1111, "R1");
    step(1'b0, 1'b1, 4'b1111, "R2");
    step(1'b0, 1'b1, 4'b1111, "R2");
    step(1'b0, 1'b0, 4'b0000, "R4");
  endtask

  initial begin
    t_reset();
    t_stream();
    t_empty_mix();
    t_pause();
    t_offered_not_taken();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule